// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

This block compares two IEEE 754 binary32 values and returns the outcome as an integer. It supports three relations: equality, strictly-less-than and less-than-or-equal. The relation is always taken with the first operand on the left, so the three questions are A = B, A < B and A ≤ B. The outcome is a single bit placed at bit 0 of an integer word whose upper bits are zero. The block also returns an invalid-operation flag.

The equality relation is a quiet compare. It raises the flag only for a signaling NaN. The two ordering relations are signaling compares and raise the flag for any NaN. Every relation returns 0 when either operand is a NaN. The compare logic is purely combinational. Its outcome is captured in an output register, so each accepted request produces its answer one clock later, together with an output strobe.

Top module: `fcmp_unit`

## Requirements
- R1: With `in_op` = 2'b00 (equal), `out_result` is 1 when A and B are numerically equal and 0 otherwise; bits 31 to 1 of `out_result` are always 0.
- R2: With `in_op` = 2'b01 (less-than), `out_result` is 1 exactly when A is strictly below B; the relation is never evaluated with the operands swapped.
- R3: With `in_op` = 2'b10 (less-or-equal), `out_result` is 1 exactly when A is below or equal to B.
- R4: +0 (0x00000000) and -0 (0x80000000) are equal in every pairing: equal gives 1, less-than gives 0, less-or-equal gives 1.
- R5: Non-NaN values are ordered by sign and magnitude: a negative value with the larger magnitude is the smaller number, subnormals are ordered normally, and the infinities (exponent field all ones, fraction zero) are the extreme values; no non-NaN pair raises `out_invalid` under any operation.
- R6: A NaN is an operand with exponent field 0xFF and a nonzero fraction. When either operand is a NaN, `out_result` is 0 for every operation.
- R7: Under less-than and less-or-equal, `out_invalid` is 1 whenever either operand is a NaN, quiet or signaling.
- R8: Under equal, `out_invalid` is 1 only when an operand is a signaling NaN (NaN with fraction bit 22 = 0); quiet NaNs (fraction bit 22 = 1) leave it 0.
- R9: `in_op` = 2'b11 yields `out_result` = 0 and `out_invalid` = 0 for any operands.
- R10: A request accepted on a rising edge with `in_valid` high shows its result, flag and `out_valid` = 1 after that edge. After an edge with `in_valid` low, `out_valid`, `out_result` and `out_invalid` are all 0. Synchronous reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Relation select: 00 equal, 01 less-than, 10 less-or-equal, 11 none |
| in_a | input | 32 | First source operand (left side) |
| in_b | input | 32 | Second source operand (right side) |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 32 | Zero-extended Boolean outcome |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
The hardest cases to reach are the ones that random operands almost never produce. These are signaling versus quiet NaNs under the equality relation, a negative NaN paired with an infinity, and the two signed zeros. A purely random run would hit them at a negligible rate. The bench therefore sweeps every ordered pair from a fixed set of special encodings under all four operation codes, so each corner case occurs in both operand positions. It then adds random bit patterns and random same-sign magnitude pairs to cover ordinary ordering. All expected outcomes come from a signed integer ordering key computed in the bench.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    parameter int unsigned FP_EXP_W  = 8;
    parameter int unsigned FP_FRAC_W = 23;
    parameter int unsigned FP_W      = 1 + FP_EXP_W + FP_FRAC_W;
    parameter int unsigned INT_W     = 32;

    localparam int unsigned MAG_W    = FP_W - 1;
    localparam int unsigned QBIT     = FP_FRAC_W - 1;

    typedef enum logic [1:0] {
        CMP_EQ   = 2'b00,
        CMP_LT   = 2'b01,
        CMP_LE   = 2'b10,
        CMP_NONE = 2'b11
    } cmp_op_e;

    typedef struct packed {
        logic             sign;
        logic             is_zero;
        logic             is_inf;
        logic             is_nan;
        logic             is_snan;
        logic [MAG_W-1:0] mag;
    } fp_class_t;

    typedef struct packed {
        logic eq;
        logic lt;
    } order_t;

    typedef struct packed {
        logic hit;
        logic invalid;
    } verdict_t;

    function automatic fp_class_t fp_classify(input logic [FP_W-1:0] v);
        fp_class_t c;
        logic [FP_EXP_W-1:0]  e;
        logic [FP_FRAC_W-1:0] f;
        e = v[FP_W-2 -: FP_EXP_W];
        f = v[FP_FRAC_W-1:0];
        c.sign    = v[FP_W-1];
        c.mag     = v[MAG_W-1:0];
        c.is_zero = (e == '0) && (f == '0);
        c.is_inf  = (e == '1) && (f == '0);
        c.is_nan  = (e == '1) && (f != '0);
        c.is_snan = c.is_nan && !f[QBIT];
        return c;
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
(
    input  logic [FP_W-1:0] opnd,
    output fp_class_t       cls
);

    always_comb begin
        cls = fp_classify(opnd);
    end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  fp_class_t lhs,
    input  fp_class_t rhs,
    output order_t    ord
);

    logic both_zero;
    logic same_bits;
    logic mag_below;
    logic mag_above;

    always_comb begin
        both_zero = lhs.is_zero && rhs.is_zero;
        same_bits = (lhs.sign == rhs.sign) && (lhs.mag == rhs.mag);
        mag_below = lhs.mag < rhs.mag;
        mag_above = lhs.mag > rhs.mag;

        ord.eq = both_zero || same_bits;

        if (both_zero) begin
            ord.lt = 1'b0;
        end else if (lhs.sign != rhs.sign) begin
            ord.lt = lhs.sign;
        end else if (!lhs.sign) begin
            ord.lt = mag_below;
        end else begin
            ord.lt = mag_above;
        end
    end

endmodule

// File: rtl/fcmp_resolve.sv
module fcmp_resolve
    import fcmp_pkg::*;
(
    input  logic [1:0] op,
    input  fp_class_t  lhs,
    input  fp_class_t  rhs,
    input  order_t     ord,
    output verdict_t   vd
);

    logic any_nan;
    logic any_snan;

    always_comb begin
        any_nan  = lhs.is_nan || rhs.is_nan;
        any_snan = lhs.is_snan || rhs.is_snan;
        vd       = '0;
        unique case (cmp_op_e'(op))
            CMP_EQ: begin
                vd.hit     = ord.eq && !any_nan;
                vd.invalid = any_snan;
            end
            CMP_LT: begin
                vd.hit     = ord.lt && !any_nan;
                vd.invalid = any_nan;
            end
            CMP_LE: begin
                vd.hit     = (ord.lt || ord.eq) && !any_nan;
                vd.invalid = any_nan;
            end
            default: begin
                vd.hit     = 1'b0;
                vd.invalid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic [FP_W-1:0]  in_a,
    input  logic [FP_W-1:0]  in_b,
    output logic             out_valid,
    output logic [INT_W-1:0] out_result,
    output logic             out_invalid
);

    localparam int unsigned NUM_SRC = 2;

    logic [FP_W-1:0] src [NUM_SRC];
    fp_class_t       cls [NUM_SRC];
    order_t          ord;
    verdict_t        vd;

    assign src[0] = in_a;
    assign src[1] = in_b;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cls
        fcmp_classify u_cls (
            .opnd (src[g]),
            .cls  (cls[g])
        );
    end

    fcmp_order u_order (
        .lhs (cls[0]),
        .rhs (cls[1]),
        .ord (ord)
    );

    fcmp_resolve u_resolve (
        .op  (in_op),
        .lhs (cls[0]),
        .rhs (cls[1]),
        .ord (ord),
        .vd  (vd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_result  <= {{(INT_W-1){1'b0}}, in_valid & vd.hit};
            out_invalid <= in_valid & vd.invalid;
        end
    end

endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk
    import fcmp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       in_op,
    input logic [FP_W-1:0]  in_a,
    input logic [FP_W-1:0]  in_b,
    input logic             out_valid,
    input logic [INT_W-1:0] out_result,
    input logic             out_invalid
);

    logic a_nan, b_nan, a_snan, b_snan;
    assign a_nan  = (in_a[FP_W-2 -: FP_EXP_W] == '1) && (in_a[FP_FRAC_W-1:0] != '0);
    assign b_nan  = (in_b[FP_W-2 -: FP_EXP_W] == '1) && (in_b[FP_FRAC_W-1:0] != '0);
    assign a_snan = a_nan && !in_a[FP_FRAC_W-1];
    assign b_snan = b_nan && !in_b[FP_FRAC_W-1];

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_result[INT_W-1:1] == '0); // R1

    AST_NAN_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        in_valid && (a_nan || b_nan) |=> out_result == '0); // R6

    AST_ORDER_NAN_FLAG: assert property (@(posedge clk) disable iff (rst)
        in_valid && (in_op == 2'b01 || in_op == 2'b10) && (a_nan || b_nan)
        |=> out_invalid); // R7

    AST_EQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_op == 2'b00 && !a_snan && !b_snan |=> !out_invalid); // R8

    AST_NONE_SILENT: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_op == 2'b11 |=> out_result == '0 && !out_invalid); // R9

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R10

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && out_result == '0 && !out_invalid); // R10

endmodule

bind fcmp_unit fcmp_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .in_a        (in_a),
    .in_b        (in_b),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_invalid (out_invalid)
);

// File: tb/sim_fcmp_unit.sv
module sim_fcmp_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_op;
    logic [31:0] in_a;
    logic [31:0] in_b;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fcmp_unit u0 (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_op       (in_op),
        .in_a        (in_a),
        .in_b        (in_b),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_invalid (out_invalid)
    );

    logic [31:0] pat [24];
    initial begin
        pat[0]  = 32'h00000000; pat[1]  = 32'h80000000; pat[2]  = 32'h00000001;
        pat[3]  = 32'h80000001; pat[4]  = 32'h007FFFFF; pat[5]  = 32'h3F800000;
        pat[6]  = 32'hBF800000; pat[7]  = 32'h3FC00000; pat[8]  = 32'hBFC00000;
        pat[9]  = 32'h40000000; pat[10] = 32'hC0000000; pat[11] = 32'h7F7FFFFF;
        pat[12] = 32'hFF7FFFFF; pat[13] = 32'h7F800000; pat[14] = 32'hFF800000;
        pat[15] = 32'h7FC00000; pat[16] = 32'hFFC00000; pat[17] = 32'h7F800001;
        pat[18] = 32'hFFA00000; pat[19] = 32'h7FFFFFFF; pat[20] = 32'h00800000;
        pat[21] = 32'h3F800001; pat[22] = 32'hBF800001; pat[23] = 32'h7FBFFFFF;
    end

    function automatic bit is_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic bit is_snan(input logic [31:0] v);
        return is_nan(v) && !v[22];
    endfunction

    function automatic longint key(input logic [31:0] v);
        longint m;
        m = longint'(v[30:0]);
        return v[31] ? -m : m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        bit    nan, exp_hit, exp_flag, spec;
        string rtag, ftag;
        nan  = is_nan(a) || is_nan(b);
        spec = a[31] || b[31] || (a[30:23] == 8'hFF) || (b[30:23] == 8'hFF);
        case (op)
            2'b00: exp_hit = !nan && (key(a) == key(b));
            2'b01: exp_hit = !nan && (key(a) <  key(b));
            2'b10: exp_hit = !nan && (key(a) <= key(b));
            default: exp_hit = 1'b0;
        endcase
        case (op)
            2'b00: exp_flag = is_snan(a) || is_snan(b);
            2'b01, 2'b10: exp_flag = nan;
            default: exp_flag = 1'b0;
        endcase
        if (op == 2'b11)                                   rtag = "R9";
        else if (nan)                                      rtag = "R6";
        else if (key(a) == 0 && key(b) == 0)               rtag = "R4";
        else if (spec && op != 2'b00)                      rtag = "R5";
        else if (op == 2'b00)                              rtag = "R1";
        else if (op == 2'b01)                              rtag = "R2";
        else                                               rtag = "R3";
        if (op == 2'b11)      ftag = "R9";
        else if (op == 2'b00) ftag = "R8";
        else if (nan)         ftag = "R7";
        else                  ftag = "R5";
        in_valid = 1'b1;
        in_op    = op;
        in_a     = a;
        in_b     = b;
        @(negedge clk);
        check("R10", {31'b0, out_valid}, 32'd1);
        check(rtag, out_result, {31'b0, exp_hit});
        check(ftag, {31'b0, out_invalid}, {31'b0, exp_flag});
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_op = 2'b00; in_a = '0; in_b = '0;
        repeat (3) @(negedge clk);
        check("R10", {29'b0, out_valid, out_invalid, |out_result}, 32'd0);
        rst = 1'b0;

        for (int op = 0; op < 4; op++)
            for (int i = 0; i < 24; i++)
                for (int j = 0; j < 24; j++)
                    apply(2'(op), pat[i], pat[j]);

        in_valid = 1'b0;
        in_a = 32'h3F800000; in_b = 32'h3F800000; in_op = 2'b00;
        @(negedge clk);
        check("R10", {29'b0, out_valid, out_invalid, |out_result}, 32'd0);

        for (int k = 0; k < 1500; k++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (k % 3 == 0) rb = {ra[31], rb[30:0]};
            apply(2'($urandom_range(0, 3)), ra, rb);
        end

        apply(2'b10, 32'h3F800000, 32'h40000000);
        apply(2'b10, 32'h40000000, 32'h3F800000);
        apply(2'b01, 32'hC0000000, 32'hBF800000);
        apply(2'b01, 32'hBF800000, 32'hC0000000);

        rst = 1'b1;
        in_valid = 1'b1; in_op = 2'b10; in_a = 32'h0; in_b = 32'h0;
        @(negedge clk);
        check("R10", {29'b0, out_valid, out_invalid, |out_result}, 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R10 actual=watchdog expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule